// File: doc/BRIEF.md
# Decode-Stage Branch Direction Checker

This block sits at the decode stage of an in-order pipeline and checks the next-PC guess that fetch attached to each instruction. It keeps a table of two-bit saturating counters. Each counter records how branches that map to it have resolved before. The entry is chosen by the word-address bits of the instruction's PC. For a decoded branch, the counter's upper bit gives the direction. The block then forms its own next PC: the PC plus the instruction's offset when the branch is predicted taken, and PC+4 otherwise.

When a valid branch produces a next PC that differs from the one fetch supplied, the block raises a redirect. The redirect carries the branch's PC and the corrected next PC, so that fetch can be steered. Instructions that are not branches never redirect.

A separate training port takes resolved outcomes from execute and moves the addressed counter by one step toward the outcome. The lookup path is purely combinational from the table registers. A training write lands on the following clock edge.

Top module: `bht_decode_check`

## Requirements
- R1: Counter encoding is 11 strongly taken, 10 weakly taken, 01 weakly not-taken, 00 strongly not-taken. A valid branch is predicted taken (`pred_taken`=1) exactly when its counter's bit 1 is set.
- R2: A training event with `trn_taken`=1 raises the addressed counter by one and stops at 11. With `trn_taken`=0 it lowers the counter by one and stops at 00.
- R3: After a synchronous reset (`rst_n` low at a clock edge), every counter holds 01, so every branch is predicted not-taken.
- R4: Starting from a strongly held state, the predicted direction changes only after two consecutive opposite training outcomes.
- R5: The entry is selected by PC bits [IDX_W+1:2]. PCs that differ only in bits 1:0 or above bit IDX_W+1 share one counter.
- R6: For a valid branch, `dec_npc` is `dec_pc + dec_offset` (offset two's complement, sum modulo 2^PC_W) when predicted taken, and `dec_pc + 4` otherwise.
- R7: `redir_valid` is 1 exactly when a valid branch's `dec_npc` differs from `dec_fetch_npc`. It then presents `redir_pc` = `dec_pc` and `redir_npc` = `dec_npc`.
- R8: For a non-branch, `dec_npc` is `dec_pc + 4`, `pred_taken` is 0 and `redir_valid` is 0, whatever `dec_fetch_npc` is. With `dec_valid` low, `redir_valid` is 0.
- R9: When a training write and a lookup address the same entry in one cycle, the lookup shows the counter value from before the write. The new value is visible from the next cycle on.
- R10: With `trn_valid` low, no counter changes, whatever `trn_pc` and `trn_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_pc | input | PC_W | PC of the decoded instruction |
| dec_fetch_npc | input | PC_W | Next PC guessed by fetch |
| dec_is_branch | input | 1 | Instruction is a conditional branch |
| dec_offset | input | PC_W | Branch offset, two's complement |
| pred_taken | output | 1 | Direction prediction for the branch |
| dec_npc | output | PC_W | Next PC derived at decode |
| redir_valid | output | 1 | Fetch guess disagrees; redirect fetch |
| redir_pc | output | PC_W | PC of the redirecting branch |
| redir_npc | output | PC_W | Corrected next PC |
| trn_valid | input | 1 | A resolved branch outcome is present |
| trn_pc | input | PC_W | PC of the resolved branch |
| trn_taken | input | 1 | Resolved direction |

## Verification
Counter saturation is pushed from both ends and then stepped back. A counter that wraps instead of sticking at 11 or 00 would show the wrong direction one step later. The two-step hysteresis is traced outcome by outcome, which catches a one-bit scheme that flips on the first miss. The same-entry train-and-lookup cycle is sampled before and after the edge, so a bypassed read would report the new direction too early. Aliasing PCs, a wrapping target, a negative offset, non-branches carrying a wrong fetch guess, and training with the valid bit low are each probed at the outputs. An index taken from the wrong bits, an unmasked redirect, or a write with no enable would each show up there.

// File: rtl/bht_pkg.sv
// Shared types and the counter step function for the decode-stage
// direction checker. Assumes a two-bit counter per table entry.
package bht_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;  // strongly not-taken
    localparam ctr_t CTR_WNT = 2'b01;  // weakly not-taken (reset value)
    localparam ctr_t CTR_WTK = 2'b10;  // weakly taken
    localparam ctr_t CTR_STK = 2'b11;  // strongly taken

    // One saturating step toward the resolved outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) nxt = (cur == CTR_STK) ? cur : ctr_t'(cur + 2'd1);
        else       nxt = (cur == CTR_SNT) ? cur : ctr_t'(cur - 2'd1);
        return nxt;
    endfunction

endpackage

// File: rtl/bht_counter_table.sv
// Table of 2^IDX_W saturating direction counters.
// One combinational read port for lookup, one write port for training.
// A write lands at the clock edge, so a same-cycle read sees the old value.
// Assumes a synchronous active-low reset that loads every entry with weakly not-taken.
module bht_counter_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             trn_en,
    input  logic [IDX_W-1:0] trn_idx,
    input  logic             trn_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ent_q [DEPTH];
    ctr_t trn_cur;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ctr_t cell_q;
        // Per-entry counter: reset to weakly not-taken, step on a matching train.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= CTR_WNT;
            else if (trn_en && (trn_idx == IDX_W'(g)))
                cell_q <= ctr_step(cell_q, trn_taken);
        end
        assign ent_q[g] = cell_q;
    end

    // Lookup and training reads come straight from the registers.
    assign rd_ctr  = ent_q[rd_idx];
    assign trn_cur = ent_q[trn_idx];

    // R2: taken training at the top stays at the top.
    p_sat_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_en && trn_taken && trn_cur == CTR_STK) |=> ent_q[$past(trn_idx)] == CTR_STK);

    // R2: not-taken training at the bottom stays at the bottom.
    p_sat_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_en && !trn_taken && trn_cur == CTR_SNT) |=> ent_q[$past(trn_idx)] == CTR_SNT);

    // R4: a taken outcome on a weakly not-taken entry moves it to weakly taken.
    p_weak_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_en && trn_taken && trn_cur == CTR_WNT) |=> ent_q[$past(trn_idx)] == CTR_WTK);

    // R10: without training the looked-up entry keeps its value.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trn_en |=> ent_q[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/bht_next_pc.sv
// Decode-side next-PC formation and the comparison with fetch's guess.
// Purely combinational. Assumes fixed 4-byte instructions and a sign-extended offset.
module bht_next_pc
    import bht_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            dec_valid,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] fetch_npc,
    input  logic            is_branch,
    input  logic [PC_W-1:0] offset,
    input  ctr_t            ctr,
    output logic            taken,
    output logic [PC_W-1:0] npc,
    output logic            mismatch
);

    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] tgt_pc;

    // Direction, both candidate next PCs, and the disagreement with fetch.
    always_comb begin
        seq_pc   = pc + INSN_BYTES;
        tgt_pc   = pc + offset;
        taken    = dec_valid && is_branch && ctr[1];
        npc      = taken ? tgt_pc : seq_pc;
        mismatch = dec_valid && is_branch && (npc != fetch_npc);
    end

endmodule

// File: rtl/bht_decode_check.sv
// Decode-stage branch direction checker: looks up a 2-bit counter by PC,
// derives the next PC and flags disagreement with fetch's prediction.
// Training from execute updates the table. Assumes word-aligned PCs.
module bht_decode_check
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [PC_W-1:0] dec_pc,
    input  logic [PC_W-1:0] dec_fetch_npc,
    input  logic            dec_is_branch,
    input  logic [PC_W-1:0] dec_offset,
    output logic            pred_taken,
    output logic [PC_W-1:0] dec_npc,
    output logic            redir_valid,
    output logic [PC_W-1:0] redir_pc,
    output logic [PC_W-1:0] redir_npc,
    input  logic            trn_valid,
    input  logic [PC_W-1:0] trn_pc,
    input  logic            trn_taken
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    ctr_t            look_ctr;
    logic            mism;
    logic [PC_W-1:0] npc_w;

    bht_counter_table #(.IDX_W(IDX_W)) tbl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (dec_pc[IDX_HI:IDX_LO]),
        .rd_ctr    (look_ctr),
        .trn_en    (trn_valid),
        .trn_idx   (trn_pc[IDX_HI:IDX_LO]),
        .trn_taken (trn_taken)
    );

    bht_next_pc #(.PC_W(PC_W)) npc_i (
        .dec_valid (dec_valid),
        .pc        (dec_pc),
        .fetch_npc (dec_fetch_npc),
        .is_branch (dec_is_branch),
        .offset    (dec_offset),
        .ctr       (look_ctr),
        .taken     (pred_taken),
        .npc       (npc_w),
        .mismatch  (mism)
    );

    // Redirect outputs follow the mismatch and carry the branch PC.
    always_comb begin
        dec_npc     = npc_w;
        redir_valid = mism;
        redir_pc    = dec_pc;
        redir_npc   = npc_w;
    end

    // R8: only a valid branch may redirect.
    p_redir_branch_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (dec_valid && dec_is_branch));

    // R7: a redirect always disagrees with fetch's guess.
    p_redir_differs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_npc != dec_fetch_npc));

    // R1: a taken prediction comes from a valid branch.
    p_taken_branch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> (dec_valid && dec_is_branch));

endmodule

// File: tb/bht_decode_check_tb_top.sv
module bht_decode_check_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_pc = '0;
    logic [31:0] dec_fetch_npc = '0;
    logic        dec_is_branch = 1'b0;
    logic [31:0] dec_offset = '0;
    logic        pred_taken;
    logic [31:0] dec_npc;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic [31:0] redir_npc;
    logic        trn_valid = 1'b0;
    logic [31:0] trn_pc = '0;
    logic        trn_taken = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    bht_decode_check dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_fetch_npc(dec_fetch_npc),
        .dec_is_branch(dec_is_branch), .dec_offset(dec_offset),
        .pred_taken(pred_taken), .dec_npc(dec_npc),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
        .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_taken(trn_taken)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] fnpc;
        logic        br;
        logic [31:0] ofs;
        logic        exp_tk;
        logic [31:0] exp_npc;
        logic        exp_rd;
    } vec_t;

    // Lookups right after reset: every counter weakly not-taken.
    localparam vec_t VECS [6] = '{
        '{32'h0000_0100, 32'h0000_0104, 1'b1, 32'h0000_0040, 1'b0, 32'h0000_0104, 1'b0},
        '{32'h0000_0100, 32'h0000_0140, 1'b1, 32'h0000_0040, 1'b0, 32'h0000_0104, 1'b1},
        '{32'h0000_0200, 32'h0000_0204, 1'b0, 32'h0000_0010, 1'b0, 32'h0000_0204, 1'b0},
        '{32'h0000_0200, 32'h0000_0999, 1'b0, 32'h0000_0010, 1'b0, 32'h0000_0204, 1'b0},
        '{32'hFFFF_FFFC, 32'h0000_0000, 1'b1, 32'h0000_0008, 1'b0, 32'h0000_0000, 1'b0},
        '{32'h0000_0300, 32'h0000_0000, 1'b1, 32'hFFFF_FFF0, 1'b0, 32'h0000_0304, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] pc, input logic [31:0] fnpc,
                        input logic br, input logic [31:0] ofs);
        @(negedge clk);
        dec_valid = 1'b1; dec_pc = pc; dec_fetch_npc = fnpc;
        dec_is_branch = br; dec_offset = ofs;
        #2;
    endtask

    task automatic train(input logic [31:0] pc, input logic tk);
        @(negedge clk);
        trn_valid = 1'b1; trn_pc = pc; trn_taken = tk;
        @(posedge clk);
        #1 trn_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R3 / R6 / R7 / R8: table walk after reset.
        foreach (VECS[i]) begin
            look(VECS[i].pc, VECS[i].fnpc, VECS[i].br, VECS[i].ofs);
            chk("R3 pred_taken", 32'(pred_taken), 32'(VECS[i].exp_tk));
            chk("R6 dec_npc", dec_npc, VECS[i].exp_npc);
            chk("R7 redir_valid", 32'(redir_valid), 32'(VECS[i].exp_rd));
        end

        // R8: dec_valid low never redirects.
        look(32'h100, 32'h777, 1'b1, 32'h40);
        dec_valid = 1'b0; #1;
        chk("R8 invalid no redirect", 32'(redir_valid), 32'd0);

        // R1 / R2: one taken step makes 0x100 weakly taken.
        train(32'h100, 1'b1);
        look(32'h100, 32'h104, 1'b1, 32'h40);
        chk("R1 taken after one step", 32'(pred_taken), 32'd1);
        chk("R6 taken target", dec_npc, 32'h140);
        chk("R7 redirect raised", 32'(redir_valid), 32'd1);
        chk("R7 redir_pc", redir_pc, 32'h100);
        chk("R7 redir_npc", redir_npc, 32'h140);
        look(32'h100, 32'h140, 1'b1, 32'h40);
        chk("R7 agreement no redirect", 32'(redir_valid), 32'd0);

        // R6: negative offset.
        train(32'h400, 1'b1);
        look(32'h400, 32'h3E0, 1'b1, 32'hFFFF_FFE0);
        chk("R6 negative offset", dec_npc, 32'h3E0);

        // R5: aliasing PCs share the entry; a neighbour does not.
        look(32'h1100, 32'h0, 1'b1, 32'h8);
        chk("R5 alias high bit", 32'(pred_taken), 32'd1);
        look(32'h102, 32'h0, 1'b1, 32'h8);
        chk("R5 alias low bits", 32'(pred_taken), 32'd1);
        look(32'h104, 32'h0, 1'b1, 32'h8);
        chk("R5 neighbour separate", 32'(pred_taken), 32'd0);

        // R2 / R4: saturate at 11, then two not-taken steps to flip.
        for (int k = 0; k < 3; k++) train(32'h100, 1'b1);
        train(32'h100, 1'b0);
        look(32'h100, 32'h0, 1'b1, 32'h40);
        chk("R4 one miss keeps taken", 32'(pred_taken), 32'd1);
        train(32'h100, 1'b0);
        look(32'h100, 32'h0, 1'b1, 32'h40);
        chk("R4 second miss flips", 32'(pred_taken), 32'd0);

        // R2: saturate at 00, then two taken steps to reach 10.
        train(32'h100, 1'b0);
        train(32'h100, 1'b0);
        train(32'h100, 1'b1);
        look(32'h100, 32'h0, 1'b1, 32'h40);
        chk("R2 low saturation", 32'(pred_taken), 32'd0);
        train(32'h100, 1'b1);
        look(32'h100, 32'h0, 1'b1, 32'h40);
        chk("R2 climbs from floor", 32'(pred_taken), 32'd1);

        // R10: training data with valid low changes nothing.
        @(negedge clk);
        trn_valid = 1'b0; trn_pc = 32'h500; trn_taken = 1'b1;
        repeat (4) @(posedge clk);
        look(32'h500, 32'h0, 1'b1, 32'h20);
        chk("R10 no write without valid", 32'(pred_taken), 32'd0);

        // R9: same-cycle train and lookup on 0x600.
        @(negedge clk);
        dec_valid = 1'b1; dec_pc = 32'h600; dec_fetch_npc = 32'h604;
        dec_is_branch = 1'b1; dec_offset = 32'h40;
        trn_valid = 1'b1; trn_pc = 32'h600; trn_taken = 1'b1;
        #2;
        chk("R9 old value same cycle", 32'(pred_taken), 32'd0);
        @(posedge clk);
        #1 trn_valid = 1'b0;
        #2;
        chk("R9 new value next cycle", 32'(pred_taken), 32'd1);

        // R3: reset restores weakly not-taken.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        look(32'h600, 32'h604, 1'b1, 32'h40);
        chk("R3 reset clears entry", 32'(pred_taken), 32'd0);

        dec_valid = 1'b0;
        finish_run();
    end

endmodule